// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides on which clock edges the output-driver impedance of a synchronous memory may be recalibrated. It counts every clock edge, whatever the cycle type and whether the device is selected or not. It grants a recalibration only when two conditions hold. First, enough edges have passed since the previous one. Second, the outputs are idle on that edge, meaning the device is deselected or the output enable is inactive. The user therefore never sees the access timing change because of a recalibration.

A second counter runs independently and tallies non-read edges since reset. A non-read edge is one where the device is deselected or is doing a write. Once the tally reaches the configured target, a settled flag rises. It stays high until the next reset. The grant is a single-cycle strobe that leaves a register. A continuous run of idle edges yields at most one strobe, so a further recalibration has to wait for the outputs to be driven at least once.

Top module: `zq_update_sched`

## Requirements
- R1: While reset is active, and on the first sample after it, `upd_strobe` and `settled` are both 0.
- R2: `upd_strobe` is never high in the cycle after a clock edge that sampled `sel`=1 and `oe_n`=0, because that edge drives the outputs.
- R3: Strobes are at least GAP_CYCLES (default 32) clock edges apart. The first strobe after reset release comes no earlier than the GAP_CYCLES-th edge.
- R4: The gap counter advances on every edge, including reads and writes. If at least GAP_CYCLES-1 edges have passed since the last strobe, or since reset, then the first idle edge (`sel`=0 or `oe_n`=1) that follows a driving edge raises `upd_strobe` in the next cycle. For example, after a long run of reads, the first edge with `oe_n`=1 fires.
- R5: Within one unbroken run of idle edges at most one strobe is issued. A new strobe needs at least one intervening edge with `sel`=1 and `oe_n`=0.
- R6: `upd_strobe` is a pulse exactly one cycle wide.
- R7: `settled` rises right after the edge on which the SETTLE_CYCLES-th (default 1024) non-read edge is counted. A non-read edge has `sel`=0 or `wr_en`=1. Read edges (`sel`=1, `wr_en`=0) are not counted, whatever `oe_n` is, and non-read edges need not be consecutive.
- R8: Once high, `settled` stays high until reset. The non-read tally saturates at SETTLE_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Cycle select, 1 = device selected |
| wr_en | input | 1 | Write enable, 1 = write cycle, 0 = read cycle when selected |
| oe_n | input | 1 | Active-low output enable; 1 disables the data outputs |
| upd_strobe | output | 1 | One-cycle grant for an impedance recalibration |
| settled | output | 1 | Set once enough non-read cycles have been counted since reset |

## Verification
Both outputs are due one cycle after the edge that samples the deciding inputs. The strobe is a registered decision on that edge. The settled flag follows the counter that increments on that edge. The bench applies each input set at a falling edge, lets one rising edge pass, and compares both outputs at the next falling edge against a running arithmetic model of the gap, the idle-run state and the non-read tally. Directed runs place the first permitted edge after reset, a long read stretch ended by raising `oe_n`, a long idle run, and a reset in mid-operation. A pseudo-random sweep covers all eight input combinations.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;

  // Classification of one sampled clock edge.
  typedef struct packed {
    logic quiet;    // outputs not driven on this edge
    logic nonread;  // edge counts toward settling
  } cyc_class_t;

  function automatic int unsigned tally_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/zq_cycle_class.sv
module zq_cycle_class
  import zq_sched_pkg::*;
(
  input  logic       sel,
  input  logic       wr_en,
  input  logic       oe_n,
  output cyc_class_t cls
);

  always_comb begin
    cls.quiet   = !sel || oe_n;
    cls.nonread = !sel || wr_en;
  end

endmodule

// File: rtl/zq_gap_timer.sv
module zq_gap_timer #(
  parameter int unsigned GAP_CYCLES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);

  localparam int unsigned W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
  localparam logic [W-1:0] LIMIT = W'(GAP_CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = (cnt_q == LIMIT);

endmodule

// File: rtl/zq_settle_ctr.sv
module zq_settle_ctr
  import zq_sched_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic done
);

  localparam int unsigned W = tally_width(SETTLE_CYCLES);
  localparam logic [W-1:0] TARGET = W'(SETTLE_CYCLES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != TARGET)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == TARGET);

endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched
  import zq_sched_pkg::*;
#(
  parameter int unsigned GAP_CYCLES    = 32,
  parameter int unsigned SETTLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic wr_en,
  input  logic oe_n,
  output logic upd_strobe,
  output logic settled
);

  cyc_class_t cls;
  logic       gap_ready;
  logic       win_used_q;
  logic       fire;
  logic       strobe_q;

  zq_cycle_class class_i (
    .sel   (sel),
    .wr_en (wr_en),
    .oe_n  (oe_n),
    .cls   (cls)
  );

  zq_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fire),
    .ready   (gap_ready)
  );

  zq_settle_ctr #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (cls.nonread),
    .done  (settled)
  );

  // Grant: quiet edge, spacing met, and this idle run not yet served.
  assign fire = cls.quiet && gap_ready && !win_used_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      win_used_q <= 1'b0;
    end else begin
      strobe_q   <= fire;
      win_used_q <= cls.quiet ? (win_used_q || fire) : 1'b0;
    end
  end

  assign upd_strobe = strobe_q;

endmodule

// File: rtl/zq_update_sched_chk.sv
module zq_update_sched_chk #(
  parameter int unsigned GAP_CYCLES = 32
) (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic wr_en,
  input logic oe_n,
  input logic upd_strobe,
  input logic settled
);

  localparam int unsigned W = $clog2(GAP_CYCLES + 1) + 1;
  localparam logic [W-1:0] CAP = W'(GAP_CYCLES);

  // Edges elapsed since a strobe was produced, as seen from outside.
  logic [W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (upd_strobe) begin
      since_q <= W'(1);
    end else if (since_q != CAP) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_quiet_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !oe_n) |=> !upd_strobe);

  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> (since_q >= CAP));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);

  assert_rise_on_nonread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(!sel || wr_en));

  assert_settled_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> settled);

endmodule

bind zq_update_sched zq_update_sched_chk #(.GAP_CYCLES(GAP_CYCLES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel),
  .wr_en      (wr_en),
  .oe_n       (oe_n),
  .upd_strobe (upd_strobe),
  .settled    (settled)
);

// File: tb/zq_update_sched_tb_top.sv
module zq_update_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 8;
  localparam int SETTLE     = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic wr_en = 1'b0;
  logic oe_n = 1'b0;
  logic upd_strobe;
  logic settled;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference model state
  int m_gap;
  int m_cnt;
  bit m_used;
  bit prev_strobe;
  bit prev_settled;

  always #(CLK_PERIOD/2) clk = ~clk;

  zq_update_sched #(.GAP_CYCLES(GAP), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .oe_n       (oe_n),
    .upd_strobe (upd_strobe),
    .settled    (settled)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic model_clear();
    m_gap = 0;
    m_cnt = 0;
    m_used = 1'b0;
    prev_strobe = 1'b0;
    prev_settled = 1'b0;
  endtask

  // Apply one input set at a falling edge and compare after the next rising edge.
  task automatic step(input logic s, input logic w, input logic o);
    bit elig, nonread, fire, exp_set;
    string tg, stag;
    sel = s; wr_en = w; oe_n = o;
    elig    = !s || o;
    nonread = !s || w;
    fire    = elig && (m_gap >= GAP - 1) && !m_used;
    tg = fire ? "R4" : (!elig ? "R2" : (m_used ? "R5" : "R3"));
    if (fire) m_gap = 0;
    else if (m_gap < GAP - 1) m_gap++;
    m_used = !elig ? 1'b0 : (m_used || fire);
    if (nonread && m_cnt < SETTLE) m_cnt++;
    exp_set = (m_cnt == SETTLE);
    stag = prev_settled ? "R8" : "R7";
    @(posedge clk);
    @(negedge clk);
    chk(tg, upd_strobe, fire);
    if (prev_strobe) chk("R6", upd_strobe, 1'b0);
    chk(stag, settled, exp_set);
    prev_strobe = upd_strobe;
    prev_settled = exp_set;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sel = 1'b0; wr_en = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk("R1 strobe in reset", upd_strobe, 1'b0);
    chk("R1 settled in reset", settled, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  initial begin
    logic [15:0] lf;
    model_clear();
    do_reset();

    // Idle from reset: first strobe on the GAP-th edge, only one per run.
    for (int i = 0; i < 3 * GAP; i++) step(1'b0, 1'b0, 1'b0);

    // Long read stretch driving outputs, then output enable released.
    for (int i = 0; i < 33; i++) step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b1);

    // Writes with outputs enabled are not quiet but do count as non-read.
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);

    // Reset mid-run clears settled (R8 until reset, R1 again).
    for (int i = 0; i < 50; i++) step(1'b0, 1'b0, 1'b1);
    do_reset();
    step(1'b1, 1'b0, 1'b0);

    // Exhaustive sweep of all input combinations in varied orders.
    for (int rep = 0; rep < 40; rep++)
      for (int c = 0; c < 8; c++) begin
        int v;
        v = (c * (rep % 7 + 1) + rep) % 8;
        step(v[2], v[1], v[0]);
      end

    // Pseudo-random run biased toward selected cycles.
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[1], lf[2] & lf[3], lf[4] & lf[5]);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule